// File: doc/BRIEF.md
# Path BIP-8 Generator with One-Shot Error Injection

This block sits in the transmit path ahead of the scrambler. It computes a bit-interleaved parity over every byte of a path frame and offers that parity for the B3 overhead byte of the following frame. Upstream framing logic supplies the byte stream together with two markers: one for the first byte of a frame and one for the byte slot that carries B3. The block puts its parity value into the B3 slot and passes every other byte through unchanged.

The stream runs through the block with no storage. The output valid follows the input valid, and the input ready follows the output ready. A byte counts only when valid and ready are both high on a clock edge. While ready is low, the source must hold its byte and markers steady, and the byte has no effect on the parity. Valid may drop between any two bytes.

For testing, a control pin arms a single inversion. A rising edge on the strobe pin, taken while the enable pin is high, causes the next B3 byte to go out complemented. The complemented byte is included in the parity like any other transmitted byte, so the following frame carries a B3 value that is correct for what was actually sent.

Top module: `path_bip8_gen`

## Requirements
- R1: `m_valid` equals `s_valid`, `s_ready` equals `m_ready`, and `m_sof`/`m_b3` repeat `s_sof`/`s_b3`. A byte with `s_b3`=0 leaves on `m_data` exactly as it came in.
- R2: Only an accepted byte (`s_valid`=1 and `m_ready`=1 at a rising clock edge) affects the parity or the frame boundary. Stalled bytes and idle cycles do not, whatever is on the data and marker pins.
- R3: Each bit `k` of the B3 value is the XOR of bit `k` over every byte transmitted in the previous frame, including that frame's own B3 byte as sent (even parity per bit column).
- R4: An accepted byte with `s_sof`=1 opens a new frame. From the next cycle on, `b3_value` shows the parity of the frame just closed and holds it until the next accepted frame start.
- R5: On a byte with `s_b3`=1, `m_data` carries the B3 value and `s_data` is ignored.
- R6: After reset, `b3_value` is 0x00. Bytes accepted before the first frame start form a frame of their own, so a B3 slot among them sends 0x00.
- R7: A rising edge of `err_strobe` while `err_en`=1 arms the injector. The next accepted B3 byte goes out bitwise complemented, and this disarms the injector.
- R8: One strobe edge inverts exactly one B3 byte, even if the strobe stays high. A strobe edge while `err_en`=0 inverts nothing.
- R9: A complemented B3 byte enters the parity of its own frame as complemented, so the next frame's B3 value reflects the inverted byte.
- R10: If a new arming edge falls in the same cycle as a B3 byte that uses up an earlier arming, that byte is complemented and the injector stays armed for the following B3 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte present |
| s_ready | output | 1 | Block can accept the input byte |
| s_data | input | DATA_W | Input byte before scrambling |
| s_sof | input | 1 | Input byte is the first of a frame |
| s_b3 | input | 1 | Input byte occupies the B3 slot |
| m_valid | output | 1 | Output byte present |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | DATA_W | Output byte, with the B3 slot filled in |
| m_sof | output | 1 | Output byte is the first of a frame |
| m_b3 | output | 1 | Output byte occupies the B3 slot |
| err_en | input | 1 | Permits arming of the one-shot inversion |
| err_strobe | input | 1 | Rising edge requests one inverted B3 byte |
| b3_value | output | DATA_W | Parity of the last completed frame |

## Verification
The bench runs many short frames with computed data and inserts stalls, so that a design that counted stalled or idle bytes would get a wrong B3 in the next frame. It checks the bytes sent before the first frame start, which must give a zero B3; a design that started counting only at the first marker, or that failed to clear on reset, would show up here. For injection, the bench covers a single pulse, a strobe held high across several frames, an edge while disabled and an edge that lands on a consuming B3 byte. A design that inverted on the level, repeated the inversion, ignored the enable or lost the re-arm would send a wrong number of inverted bytes. In the frame after every inversion, the bench checks that the complemented byte went into the parity, which catches a design that summed the uninverted value.

// File: rtl/path_bip_pkg.sv
package path_bip_pkg;

  // Frame position markers that travel beside each byte.
  typedef struct packed {
    logic sof;
    logic b3;
  } beat_mark_t;

  // Column parity update: fold one byte into the running parity.
  function automatic logic fold_col(input logic acc_bit, input logic data_bit);
    return acc_bit ^ data_bit;
  endfunction

endpackage

// File: rtl/bip_accum.sv
module bip_accum #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         sof,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] parity_q
);
  import path_bip_pkg::*;

  logic [W-1:0] acc_q;
  logic [W-1:0] hold_q;

  // One independent even-parity register per bit column.
  for (genvar c = 0; c < W; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[c]  <= 1'b0;
        hold_q[c] <= 1'b0;
      end else if (fire) begin
        if (sof) begin
          hold_q[c] <= acc_q[c];
          acc_q[c]  <= tx_byte[c];
        end else begin
          acc_q[c]  <= fold_col(acc_q[c], tx_byte[c]);
        end
      end
    end
  end

  assign parity_q = hold_q;

  // R4
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sof) |=> (hold_q == $past(acc_q)));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && sof) |=> $stable(hold_q));

endmodule

// File: rtl/err_oneshot.sv
module err_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  input  logic consume,
  output logic armed
);
  logic strobe_q;
  logic armed_q;
  logic rise;

  assign rise = strobe & ~strobe_q & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      strobe_q <= strobe;
      armed_q  <= (armed_q & ~consume) | rise;
    end
  end

  assign armed = armed_q;

  // R7
  consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && consume && !strobe) |=> !armed_q);

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !en) |=> !armed_q);

  // R8
  level_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && strobe && strobe_q) |=> !armed_q);

endmodule

// File: rtl/path_bip8_gen.sv
module path_bip8_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sof,
  input  logic              s_b3,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sof,
  output logic              m_b3,
  input  logic              err_en,
  input  logic              err_strobe,
  output logic [DATA_W-1:0] b3_value
);
  import path_bip_pkg::*;

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  beat_mark_t   mark;
  logic         fire;
  logic         slot_fire;
  logic         armed;
  logic [DATA_W-1:0] parity;
  logic [DATA_W-1:0] slot_byte;

  assign mark      = '{sof: s_sof, b3: s_b3};
  assign fire      = s_valid & m_ready;
  assign slot_fire = fire & mark.b3;

  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign m_sof   = mark.sof;
  assign m_b3    = mark.b3;

  assign slot_byte = armed ? (parity ^ ALL_ONES) : parity;
  assign m_data    = mark.b3 ? slot_byte : s_data;
  assign b3_value  = parity;

  bip_accum #(.W(DATA_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .sof      (mark.sof),
    .tx_byte  (m_data),
    .parity_q (parity)
  );

  err_oneshot u_inject (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (err_en),
    .strobe  (err_strobe),
    .consume (slot_fire),
    .armed   (armed)
  );

  // R6
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (b3_value == '0));

endmodule

// File: tb/path_bip8_gen_bench.sv
module path_bip8_gen_bench;
  localparam int W   = 8;
  localparam int FL  = 7;
  localparam int B3I = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         s_valid = 1'b0, s_ready;
  logic [W-1:0] s_data = '0;
  logic         s_sof = 1'b0, s_b3 = 1'b0;
  logic         m_valid, m_ready = 1'b0;
  logic [W-1:0] m_data;
  logic         m_sof, m_b3;
  logic         err_en = 1'b0, err_strobe = 1'b0;
  logic [W-1:0] b3_value;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_par = '0;
  logic [W-1:0] cur_par = '0;
  logic exp_inv = 1'b0;
  logic hold_strobe = 1'b0;

  path_bip8_gen #(.DATA_W(W)) u_path_bip8_gen (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_b3(s_b3),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_b3(m_b3),
    .err_en(err_en), .err_strobe(err_strobe), .b3_value(b3_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One byte; stall cycles first, optional strobe edge in the accept cycle.
  task automatic beat(input logic [W-1:0] d, input logic sof, input logic b3,
                      input int stall, input logic strobe_now);
    logic [W-1:0] exp_out;
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_sof = sof; s_b3 = b3; m_ready = 1'b0;
    err_strobe = hold_strobe;
    for (int k = 0; k < stall; k++) begin
      #2;
      chk("R2", s_ready, 0);
      chk("R1", m_valid, 1);
      @(negedge clk);
    end
    m_ready = 1'b1;
    err_strobe = strobe_now | hold_strobe;
    exp_out = b3 ? (prev_par ^ {W{exp_inv}}) : d;
    #2;
    if (b3) chk(exp_inv ? "R7/R9" : "R3/R5", m_data, exp_out);
    else    chk("R1", m_data, exp_out);
    chk("R1", {m_sof, m_b3}, {sof, b3});
    if (strobe_now && err_en) exp_inv = 1'b1;      // R10 re-arm wins
    else if (b3)              exp_inv = 1'b0;
    if (sof) begin prev_par = cur_par; cur_par = exp_out; end
    else cur_par = cur_par ^ exp_out;
    @(posedge clk); #1;
    if (sof) chk("R4", b3_value, prev_par);
  endtask

  // Idle cycles with junk on the input pins: nothing may count (R2).
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0; s_data = W'(8'hA5 + k * 17); s_sof = 1'b1; s_b3 = 1'b1;
      m_ready = k[0];
      err_strobe = hold_strobe;
      #2;
      chk("R1", m_valid, 0);
      chk("R1", s_ready, k[0]);
    end
  endtask

  task automatic frame(input int f, input int stall_at, input int strobe_at);
    for (int i = 0; i < FL; i++)
      beat(W'(f * 29 + i * 13 + 7), i == 0, i == B3I,
           (i == stall_at) ? 2 : 0, i == strobe_at);
  endtask

  task automatic pulse(input logic en);
    @(negedge clk);
    s_valid = 1'b0; err_en = en; err_strobe = 1'b1;
    @(negedge clk);
    err_strobe = 1'b0;
    if (en) exp_inv = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R6", b3_value, 0);
    chk("R1", m_valid, 0);
    rst_n = 1'b1;
    // R6: bytes before the first frame start, B3 slot sends zero
    for (int i = 0; i < 4; i++) beat(W'(8'h31 * (i + 1)), 1'b0, i == 1, 0, 1'b0);
    // R3 R4 R2: plain frames with stalls and idles
    for (int f = 0; f < 6; f++) begin
      frame(f, f % FL, -1);
      idle(f % 3);
    end
    // R7 then R9
    pulse(1'b1);
    frame(10, -1, -1);
    frame(11, 3, -1);
    chk("R7", exp_inv, 0);
    // R8: edge while disabled
    pulse(1'b0);
    frame(12, -1, -1);
    // R8: strobe held high over several frames
    err_en = 1'b1;
    hold_strobe = 1'b1;
    idle(1);
    exp_inv = 1'b1;
    frame(13, -1, -1);
    frame(14, -1, -1);
    frame(15, -1, -1);
    hold_strobe = 1'b0;
    idle(2);
    frame(16, -1, -1);
    // R10: new edge during a consuming B3 byte
    pulse(1'b1);
    frame(17, -1, B3I);
    frame(18, -1, -1);
    frame(19, -1, -1);
    // Sweep with varied stalls and injections
    for (int f = 20; f < 60; f++) begin
      if (f % 7 == 0) pulse(1'b1);
      frame(f, (f * 3) % FL, -1);
      idle(f % 2);
    end
    idle(2);
    finish_run();
  end
endmodule